// File: doc/BRIEF.md
# Two-Wire Target Register File with Supply-Fail Lockout

This block is the target side of a two-wire serial bus for a timekeeping device. One address space holds eight clock registers followed by 56 bytes of general-purpose RAM, 64 bytes in all. A controller opens a transfer with a START condition and the device address. In a write, the first data byte sets an internal register pointer and each later byte is stored where the pointer points. In a read, bytes come back one after another from the pointer. The pointer steps by one after every byte in both directions, and it survives STOP, so a read can pick up where the last access stopped.

Both bus lines are synchronised into the system clock domain. The data line is driven by an open-drain style enable, which pulls the line low when high. A supply-fail input shuts the block off the bus. While it is high, and for a parameterised number of clock cycles after it falls, the block acknowledges nothing and changes nothing. Supply sensing and the counting of time are handled elsewhere.

Top module: `i2c_rf_target`

## Requirements
- R1: The block answers only the 7-bit address 1101000, and only when the 8-bit address byte ends with a direction bit (0 = write, 1 = read). Any other address is not acknowledged, and the data that follows it leaves every register unchanged.
- R2: In a write, the first data byte loads the pointer. Each later byte is stored at the pointer, and the pointer then steps by one. Every byte, including the address byte, is acknowledged by pulling SDA low during the ninth clock.
- R3: A read returns the byte at the pointer, MSB first, and then steps the pointer. It goes on as long as the controller acknowledges. A not-acknowledge from the controller makes the block release SDA.
- R4: Addresses 0x00 to 0x07 are the clock registers and 0x08 to 0x3F are the 56 RAM bytes. Both ranges can be reached in a single burst.
- R5: The pointer wraps from 0x3F to 0x00 in both reads and writes.
- R6: A START in any state restarts the address phase, and a STOP returns the block to idle. The pointer keeps its value across transactions, so a read with no pointer byte starts at the pointer as it was left.
- R7: While pwr_fail_i is high, the address is not acknowledged, SDA is released by the next clock edge, and neither the registers nor the pointer change.
- R8: After pwr_fail_i falls, the lockout lasts REC_CYCLES rising clock edges (default 1000). After that the block answers its address again.
- R9: With the default two synchroniser stages, a written byte is committed on the third rising clk_i edge after scl_i rises for its eighth bit. If pwr_fail_i is high at that edge, the byte is dropped.
- R10: After reset SDA is released and the pointer is 0x00. The clock registers read 00 00 00 01 01 01 00 00 at addresses 0x00 to 0x07, and all RAM bytes read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls the data line low |
| pwr_fail_i | input | 1 | High while supply is below the fail threshold |

## Verification
Two events can land in the same clock cycle: the start of the lockout and the commit of a written data byte. The bench writes a clock register and raises pwr_fail_i at four positions relative to the eighth SCL rise, from the same clock edge up to three edges later. After recovery it reads the register back. The first three positions must leave the old value in place, and the last must show the new byte.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_DONE,
      ST_ACK,
      ST_WR,
      ST_WR_DONE,
      ST_RD,
      ST_MACK
   } rf_state_e;

   // clock-register slots that come out of reset holding one
   localparam int unsigned DAY_SLOT   = 3;
   localparam int unsigned DATE_SLOT  = 4;
   localparam int unsigned MONTH_SLOT = 5;

   function automatic logic [7:0] reg_init(input int unsigned idx, input int unsigned clk_regs);
      if (idx < clk_regs && (idx == DAY_SLOT || idx == DATE_SLOT || idx == MONTH_SLOT))
         return 8'h01;
      return 8'h00;
   endfunction

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
   parameter int unsigned STAGES   = 2,
   parameter logic        RST_VAL  = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("i2c_rf_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic ff_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) ff_q <= RST_VAL;
         else         ff_q <= d_i;
      end
      assign q_o = ff_q;
   end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
         else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
      assign q_o = ff_q[STAGES-1];
   end

endmodule

// File: rtl/i2c_rf_lockout.sv
module i2c_rf_lockout #(
   parameter int unsigned REC_CYCLES = 1000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwr_fail_i,
   output logic locked_o
);

   if (REC_CYCLES == 0) begin : g_no_delay
      assign locked_o = pwr_fail_i;
   end else begin : g_delay
      localparam int unsigned CNT_W = $clog2(REC_CYCLES + 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)             cnt_q <= '0;
         else if (pwr_fail_i)     cnt_q <= CNT_W'(REC_CYCLES);
         else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end

      assign locked_o = pwr_fail_i | (cnt_q != '0);
   end

endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs
   import i2c_rf_pkg::*;
#(
   parameter int unsigned CLK_REGS  = 8,
   parameter int unsigned RAM_BYTES = 56,
   parameter int unsigned DEPTH     = CLK_REGS + RAM_BYTES,
   parameter int unsigned PTR_W     = $clog2(DEPTH)
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       ptr_load_i,
   input  logic [7:0] ptr_val_i,
   input  logic       wr_en_i,
   input  logic [7:0] wr_data_i,
   input  logic       rd_adv_i,
   output logic [7:0] rd_data_o
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [7:0]       mem_q [DEPTH];
   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_next;
   logic [PTR_W-1:0] ptr_loaded;

   assign ptr_next = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);

   if (DEPTH == (1 << PTR_W)) begin : g_pow2
      assign ptr_loaded = ptr_val_i[PTR_W-1:0];
   end else begin : g_clamp
      // pointer values past the top of the map fall back to address zero
      assign ptr_loaded = (ptr_val_i < 8'(DEPTH)) ? ptr_val_i[PTR_W-1:0] : '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q <= '0;
      end else if (ptr_load_i) begin
         ptr_q <= ptr_loaded;
      end else if (wr_en_i || rd_adv_i) begin
         ptr_q <= ptr_next;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= reg_init(i, CLK_REGS);
      end else if (wr_en_i) begin
         mem_q[ptr_q] <= wr_data_i;
      end
   end

   assign rd_data_o = mem_q[ptr_q];

endmodule

// File: rtl/i2c_rf_target.sv
module i2c_rf_target
   import i2c_rf_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'b1101000,
   parameter int unsigned CLK_REGS    = 8,
   parameter int unsigned RAM_BYTES   = 56,
   parameter int unsigned REC_CYCLES  = 1000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o,
   input  logic pwr_fail_i
);

   localparam int unsigned DEPTH = CLK_REGS + RAM_BYTES;
   localparam int unsigned PTR_W = $clog2(DEPTH);

   if (DEPTH > 256 || DEPTH < 2) begin : g_bad_depth
      $error("i2c_rf_target: map must hold 2 to 256 bytes");
   end
   if (CLK_REGS < 6) begin : g_bad_clk
      $error("i2c_rf_target: at least six clock registers are expected");
   end

   // ---------------- bus line sampling ----------------
   logic scl_s, sda_s, scl_q, sda_q;

   i2c_rf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_scl_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s)
   );
   i2c_rf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sda_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   logic scl_rise, scl_fall, start_det, stop_det;
   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s & scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s & scl_q & ~sda_q &  sda_s;

   // ---------------- supply lockout ----------------
   logic locked;

   i2c_rf_lockout #(.REC_CYCLES(REC_CYCLES)) i_lockout (
      .clk_i(clk_i), .rst_ni(rst_ni), .pwr_fail_i(pwr_fail_i), .locked_o(locked)
   );

   // ---------------- protocol engine ----------------
   rf_state_e  st;
   logic [6:0] sh_q;
   logic [6:0] tx_q;
   logic [2:0] bcnt_q;
   logic       rw_q, first_q, match_q, oe_q;
   logic [7:0] new_byte;
   logic [7:0] rd_data;
   logic       go, byte_done, ptr_load, wr_en, rd_adv;

   assign new_byte  = {sh_q, sda_s};
   assign go        = ~locked & ~start_det & ~stop_det;
   assign byte_done = go & (st == ST_WR) & scl_rise & (bcnt_q == 3'd7);
   assign ptr_load  = byte_done &  first_q;
   assign wr_en     = byte_done & ~first_q;
   assign rd_adv    = go & (st == ST_ACK) & scl_fall & rw_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st      <= ST_IDLE;
         sh_q    <= '0;
         tx_q    <= '0;
         bcnt_q  <= '0;
         rw_q    <= 1'b0;
         first_q <= 1'b0;
         match_q <= 1'b0;
         oe_q    <= 1'b0;
      end else if (locked) begin
         st   <= ST_IDLE;
         oe_q <= 1'b0;
      end else if (start_det) begin
         st     <= ST_ADDR;
         bcnt_q <= '0;
         oe_q   <= 1'b0;
      end else if (stop_det) begin
         st   <= ST_IDLE;
         oe_q <= 1'b0;
      end else begin
         case (st)
            ST_ADDR: if (scl_rise) begin
               sh_q   <= new_byte[6:0];
               bcnt_q <= bcnt_q + 3'd1;
               if (bcnt_q == 3'd7) begin
                  match_q <= (new_byte[7:1] == DEV_ADDR);
                  rw_q    <= new_byte[0];
                  st      <= ST_ADDR_DONE;
               end
            end
            ST_ADDR_DONE: if (scl_fall) begin
               if (match_q) begin
                  oe_q    <= 1'b1;
                  first_q <= 1'b1;
                  st      <= ST_ACK;
               end else begin
                  st <= ST_IDLE;
               end
            end
            ST_ACK: if (scl_fall) begin
               bcnt_q <= '0;
               if (rw_q) begin
                  tx_q <= rd_data[6:0];
                  oe_q <= ~rd_data[7];
                  st   <= ST_RD;
               end else begin
                  oe_q <= 1'b0;
                  st   <= ST_WR;
               end
            end
            ST_WR: if (scl_rise) begin
               sh_q   <= new_byte[6:0];
               bcnt_q <= bcnt_q + 3'd1;
               if (bcnt_q == 3'd7) begin
                  first_q <= 1'b0;
                  st      <= ST_WR_DONE;
               end
            end
            ST_WR_DONE: if (scl_fall) begin
               oe_q <= 1'b1;
               st   <= ST_ACK;
            end
            ST_RD: if (scl_fall) begin
               if (bcnt_q == 3'd7) begin
                  oe_q <= 1'b0;
                  st   <= ST_MACK;
               end else begin
                  oe_q   <= ~tx_q[6];
                  tx_q   <= {tx_q[5:0], 1'b0};
                  bcnt_q <= bcnt_q + 3'd1;
               end
            end
            ST_MACK: if (scl_rise) begin
               st <= sda_s ? ST_IDLE : ST_ACK;
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = oe_q;

   // ---------------- register map ----------------
   i2c_rf_regs #(
      .CLK_REGS(CLK_REGS), .RAM_BYTES(RAM_BYTES), .DEPTH(DEPTH), .PTR_W(PTR_W)
   ) i_regs (
      .clk_i(clk_i),
      .rst_ni(rst_ni),
      .ptr_load_i(ptr_load),
      .ptr_val_i(new_byte),
      .wr_en_i(wr_en),
      .wr_data_i(new_byte),
      .rd_adv_i(rd_adv),
      .rd_data_o(rd_data)
   );

endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker
   import i2c_rf_pkg::*;
#(
   parameter int unsigned DEPTH      = 64,
   parameter int unsigned PTR_W      = 6,
   parameter int unsigned REC_CYCLES = 1000
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             pwr_fail_i,
   input logic             locked,
   input logic             sda_oe_o,
   input logic             start_det,
   input logic             wr_en,
   input logic             rd_adv,
   input logic [PTR_W-1:0] ptr,
   input rf_state_e        st
);

   localparam int unsigned SW = $clog2(REC_CYCLES + 2);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   // cycles since the supply-fail input was last high, saturating
   logic [SW-1:0] since_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     since_q <= SW'(REC_CYCLES);
      else if (pwr_fail_i)             since_q <= '0;
      else if (since_q != SW'(REC_CYCLES)) since_q <= since_q + 1'b1;
   end

   AST_RELEASE_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_fail_i |=> !sda_oe_o);                                         // R7
   AST_PTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked |=> $stable(ptr));                                          // R7
   AST_LOCK_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_q < SW'(REC_CYCLES)) |-> locked);                           // R8
   AST_LOCK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pwr_fail_i && since_q == SW'(REC_CYCLES)) |-> !locked);          // R8
   AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((wr_en || rd_adv) && ptr != LAST) |=> ptr == $past(ptr) + PTR_W'(1)); // R2
   AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((wr_en || rd_adv) && ptr == LAST) |=> ptr == '0);                 // R5
   AST_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_det && !locked) |=> st == ST_ADDR);                         // R6

endmodule

bind i2c_rf_target i2c_rf_checker #(
   .DEPTH(DEPTH), .PTR_W(PTR_W), .REC_CYCLES(REC_CYCLES)
) i_chk (
   .clk_i(clk_i),
   .rst_ni(rst_ni),
   .pwr_fail_i(pwr_fail_i),
   .locked(locked),
   .sda_oe_o(sda_oe_o),
   .start_det(start_det),
   .wr_en(wr_en),
   .rd_adv(rd_adv),
   .ptr(i_regs.ptr_q),
   .st(st)
);

// File: tb/test_i2c_rf_target.sv
module test_i2c_rf_target;

   localparam int CLK_PERIOD = 10;
   localparam int REC        = 300;
   localparam int Q          = 4;
   localparam int H          = 8;
   localparam logic [7:0] AW = 8'hD0;
   localparam logic [7:0] AR = 8'hD1;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic scl = 1'b1;
   logic tb_low = 1'b0;
   logic pwr_fail = 1'b0;
   logic sda_oe;
   logic sda_line;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [7:0] wbuf [8];
   logic [7:0] rbuf [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = ~(tb_low | sda_oe);

   i2c_rf_target #(.REC_CYCLES(REC)) i_i2c_rf_target (
      .clk_i(clk),
      .rst_ni(rst_ni),
      .scl_i(scl),
      .sda_i(sda_line),
      .sda_oe_o(sda_oe),
      .pwr_fail_i(pwr_fail)
   );

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // ---------------- bus primitives ----------------
   task automatic bus_start();
      wait_n(Q); tb_low = 1'b0;
      wait_n(Q); scl = 1'b1;
      wait_n(H); tb_low = 1'b1;
      wait_n(H); scl = 1'b0;
   endtask

   task automatic bus_stop();
      wait_n(Q); tb_low = 1'b1;
      wait_n(Q); scl = 1'b1;
      wait_n(H); tb_low = 1'b0;
      wait_n(H);
   endtask

   task automatic bit_out(input logic b);
      wait_n(Q); tb_low = ~b;
      wait_n(Q); scl = 1'b1;
      wait_n(H); scl = 1'b0;
   endtask

   task automatic ack_phase(output logic ack);
      wait_n(Q); tb_low = 1'b0;
      wait_n(Q); scl = 1'b1;
      wait_n(Q); ack = ~sda_line;
      wait_n(Q); scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      ack_phase(ack);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      tb_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         wait_n(2*Q); scl = 1'b1;
         wait_n(Q);   b[i] = sda_line;
         wait_n(Q);   scl = 1'b0;
      end
      wait_n(Q); tb_low = mack;
      wait_n(Q); scl = 1'b1;
      wait_n(H); scl = 1'b0;
      wait_n(Q); tb_low = 1'b0;
   endtask

   // write n bytes from wbuf starting at ptr; n = 0 only sets the pointer
   task automatic write_regs(input logic [7:0] ptr, input int n, input string tag);
      logic ack;
      bus_start();
      send_byte(AW, ack);   chk({tag, " addr ack"}, ack, 1'b1);
      send_byte(ptr, ack);  chk({tag, " ptr ack"}, ack, 1'b1);
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], ack);
         chk({tag, " data ack"}, ack, 1'b1);
      end
      bus_stop();
   endtask

   task automatic read_body(input int n, input string tag);
      logic ack;
      send_byte(AR, ack);
      chk({tag, " read addr ack"}, ack, 1'b1);
      for (int i = 0; i < n; i++) recv_byte((i != n-1), rbuf[i]);
      bus_stop();
   endtask

   task automatic read_from(input logic [7:0] ptr, input int n, input string tag);
      logic ack;
      bus_start();
      send_byte(AW, ack);  chk({tag, " addr ack"}, ack, 1'b1);
      send_byte(ptr, ack); chk({tag, " ptr ack"}, ack, 1'b1);
      bus_start();
      read_body(n, tag);
   endtask

   task automatic read_here(input int n, input string tag);
      bus_start();
      read_body(n, tag);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [7:0] exp [8];
      exp = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
      chk("R10 sda released after reset", sda_oe, 1'b0);
      read_here(8, "R10");
      for (int i = 0; i < 8; i++) chk($sformatf("R10 clock reg %0d reset value", i), rbuf[i], exp[i]);
      read_from(8'h08, 1, "R10");
      chk("R10 first RAM byte reset value", rbuf[0], 8'h00);
   endtask

   task automatic t_foreign();
      logic ack;
      bus_start();
      send_byte(8'hA0, ack);
      chk("R1 foreign address not acknowledged", ack, 1'b0);
      send_byte(8'h10, ack);
      send_byte(8'h99, ack);
      chk("R1 data after foreign address not acknowledged", ack, 1'b0);
      bus_stop();
      read_from(8'h10, 1, "R1");
      chk("R1 foreign write left RAM unchanged", rbuf[0], 8'h00);
   endtask

   task automatic t_burst();
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44; wbuf[4] = 8'h55;
      write_regs(8'h08, 5, "R2");
      read_from(8'h08, 5, "R3");
      for (int i = 0; i < 5; i++) chk($sformatf("R2 R3 burst byte %0d", i), rbuf[i], wbuf[i]);
   endtask

   task automatic t_clock_regs();
      wbuf[0] = 8'h45;
      write_regs(8'h02, 1, "R4");
      read_from(8'h00, 8, "R4");
      chk("R4 clock reg 2 written", rbuf[2], 8'h45);
      chk("R4 clock reg 3 untouched", rbuf[3], 8'h01);
      read_from(8'h06, 3, "R4");
      chk("R4 burst crosses into RAM", rbuf[2], 8'h11);
   endtask

   task automatic t_wrap();
      wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'hE3;
      write_regs(8'h3E, 3, "R5");
      read_from(8'h3F, 2, "R5");
      chk("R5 top byte", rbuf[0], 8'hE2);
      chk("R5 write and read wrap to 0x00", rbuf[1], 8'hE3);
   endtask

   task automatic t_pointer_kept();
      write_regs(8'h0A, 0, "R6");
      read_here(1, "R6");
      chk("R6 read without pointer uses kept pointer", rbuf[0], 8'h33);
      read_here(1, "R6");
      chk("R6 pointer advanced across STOP", rbuf[0], 8'h44);
   endtask

   task automatic t_master_nack();
      read_from(8'h08, 1, "R3");
      chk("R3 sda released after controller NACK", sda_oe, 1'b0);
      wait_n(H);
      chk("R3 line idle high", sda_line, 1'b1);
   endtask

   task automatic t_power_fail();
      logic ack;
      pwr_fail = 1'b1;
      wait_n(5);
      bus_start();
      send_byte(AW, ack);
      chk("R7 address refused under supply fail", ack, 1'b0);
      send_byte(8'h20, ack);
      send_byte(8'h77, ack);
      chk("R7 sda released under supply fail", sda_oe, 1'b0);
      bus_stop();
      pwr_fail = 1'b0;
      wait_n(REC + 20);
      read_from(8'h20, 1, "R7");
      chk("R7 RAM unchanged by locked write", rbuf[0], 8'h00);
   endtask

   task automatic t_recovery();
      logic ack;
      pwr_fail = 1'b1;
      wait_n(10);
      pwr_fail = 1'b0;
      wait_n(40);
      bus_start();
      send_byte(AW, ack);
      chk("R8 refused inside recovery window", ack, 1'b0);
      bus_stop();
      wait_n(REC + 20);
      bus_start();
      send_byte(AW, ack);
      chk("R8 accepted after recovery window", ack, 1'b1);
      bus_stop();
   endtask

   // raise supply-fail k clock edges after the eighth SCL rise of a data byte
   task automatic t_same_cycle();
      logic ack;
      logic [7:0] d;
      logic [7:0] expv;
      expv = 8'h01;
      for (int k = 0; k < 4; k++) begin
         d = 8'hA0 | 8'(k);
         bus_start();
         send_byte(AW, ack);
         send_byte(8'h05, ack);
         for (int i = 7; i >= 1; i--) bit_out(d[i]);
         wait_n(Q); tb_low = ~d[0];
         wait_n(Q); scl = 1'b1;
         wait_n(k); pwr_fail = 1'b1;
         wait_n(H); scl = 1'b0;
         bus_stop();
         wait_n(5);
         pwr_fail = 1'b0;
         wait_n(REC + 20);
         if (k >= 3) expv = d;
         read_from(8'h05, 1, "R9");
         chk($sformatf("R9 commit versus lockout offset %0d", k), rbuf[0], expv);
      end
   endtask

   initial begin
      wait_n(5);
      rst_ni = 1'b1;
      wait_n(5);
      t_reset();
      t_foreign();
      t_burst();
      t_clock_regs();
      t_wrap();
      t_pointer_kept();
      t_master_nack();
      t_power_fail();
      t_recovery();
      t_same_cycle();
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
   end

endmodule